// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block collects a large set of peripheral interrupt pulses and folds them onto a small number of processor request lines. With the default parameters there are 96 sources arranged as 12 groups of 8, and each group owns one request line. Every group has an 8-bit mask, an 8-bit pending word and one latch bit. The latch bit stops that group from raising a second request until software releases it.

When the processor takes an interrupt on a line, it issues a vector fetch for that line. The block then looks at that group's pending and masked word as it stands in that cycle. It picks the lowest-numbered live source, returns the address of that source's two-word vector slot and clears that pending bit. A trap-style fetch always returns the group's first slot and leaves the pending bits alone.

A 16-bit register port reaches a control word, the latch word, the per-group mask and pending words, and a 256-word vector memory. The vector memory accepts writes only while a protect-override input is high.

Top module: `gie_expander`

## Requirements
- R1: After reset, every request line is low, and the control word, latch word, every mask word and every pending word read 0.
- R2: A one-cycle high on source input g*8+s sets pending bit s of group g (0-based). A register write to a pending word replaces it, so each written 1 sets a bit and each written 0 clears it.
- R3: Group g raises `cpu_irq[g]` for exactly one cycle, and sets latch bit g, only when three things hold: the forward-enable bit (control word bit 0) is 1, the latch bit is 0, and some pending bit of the group is also unmasked.
- R4: While latch bit g is 1, group g raises no further request. Writing 1 to bit g of the latch word clears it, writing 0 there changes nothing, and a group that is still live then requests again.
- R5: A fetch gives `fetch_valid` high one cycle after `fetch_req`. With forwarding on, `fetch_addr` is 0x0D40 + 16*g + 2*s, where s is the lowest-numbered pending and unmasked source of line g, and that pending bit is cleared.
- R6: The source is chosen in the cycle of the fetch. A higher-priority source that arrives after the request went out is still served first.
- R7: A trap fetch (`fetch_trap` high) with forwarding on returns 0x0D40 + 16*g and clears no pending bit.
- R8: With forwarding off, a fetch returns 0x0D02 + 2*g and clears no pending bit.
- R9: A fetch on a line with no pending and unmasked source returns 0x0D40 + 16*g and clears nothing.
- R10: Words 0x0D00 to 0x0DFF form a 256x16 vector memory. A write there takes effect only while `prot_ovr` is 1.
- R11: Addresses 0x0CFA to 0x0CFF read as zero and ignore writes.
- R12: The control word is at 0x0CE0 (only bit 0 is stored) and the latch word is at 0x0CE1. The mask word of group g is at 0x0CE2 + 2*g and its pending word is at the next address. Both hold 8 bits and read back zero-extended. Read data appears one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 96 | One-cycle source pulses, bit g*8+s for group g, source s |
| prot_ovr | input | 1 | Enables writes to the vector memory |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| cpu_irq | output | 12 | One-cycle request pulse per group |
| fetch_req | input | 1 | Vector fetch strobe |
| fetch_line | input | 4 | Line (group) being fetched, 0-based |
| fetch_trap | input | 1 | Fetch is a trap: fixed first slot, no clearing |
| fetch_valid | output | 1 | Fetch result valid |
| fetch_addr | output | 16 | Vector slot address |

## Verification
The bench raises two sources in one group at once and expects two fetches to return them in index order. A design that resolved priority in the wrong direction would hand out the high-index slot first. It also raises a low-index source after the request has already gone out; a design that froze its choice at request time would return the stale, lower-priority slot. Latch handling is probed by keeping a group live while its latch is set and expecting exactly one more pulse after the write-one release. Trap fetches, fetches with forwarding off, masked-only pending words, blocked vector-memory writes and writes to reserved addresses are each checked to leave their state unchanged.

// File: rtl/gie_pkg.sv
package gie_pkg;

    // fixed word addresses of the register window
    localparam logic [15:0] CTRL_ADDR      = 16'h0CE0;
    localparam logic [15:0] ACK_ADDR       = 16'h0CE1;
    localparam logic [15:0] GRP_REG_BASE   = 16'h0CE2;
    localparam logic [15:0] TBL_BASE       = 16'h0D00;
    localparam logic [15:0] CORE_SLOT_BASE = 16'h0D02;
    localparam logic [15:0] GRP_VEC_BASE   = 16'h0D40;

    // each vector slot spans this many words
    localparam int VEC_WORDS = 2;

endpackage

// File: rtl/gie_group.sv
module gie_group #(
    parameter  int SRCS = 8,
    localparam int SW   = (SRCS > 1) ? $clog2(SRCS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] src_pulse,
    input  logic            xen,
    input  logic            en_we,
    input  logic            flag_we,
    input  logic [SRCS-1:0] wdata,
    input  logic            ack_clr,
    input  logic            take,
    output logic [SRCS-1:0] enable_o,
    output logic [SRCS-1:0] flag_o,
    output logic            ack_o,
    output logic            irq_o,
    output logic            any_o,
    output logic [SW-1:0]   idx_o
);

    typedef struct packed {
        logic [SRCS-1:0] enable;
        logic [SRCS-1:0] flag;
        logic            ack;
        logic            irq;
    } grp_t;

    grp_t            st_d, st_q;
    logic [SRCS-1:0] live;
    logic [SW-1:0]   pick;
    logic            hit;
    logic            fire;

    always_comb begin
        live = st_q.flag & st_q.enable;
        hit  = |live;
        pick = '0;
        // walk from the top so the lowest live index is the last one kept
        for (int i = SRCS - 1; i >= 0; i--) begin
            if (live[i]) pick = SW'(i);
        end
        fire = xen && !st_q.ack && hit;

        st_d = st_q;
        if (en_we)   st_d.enable = wdata;
        if (flag_we) st_d.flag   = wdata;
        if (take && hit) st_d.flag[pick] = 1'b0;
        // a fresh pulse always wins over a clear in the same cycle
        st_d.flag = st_d.flag | src_pulse;
        st_d.irq  = fire;
        if (fire)         st_d.ack = 1'b1;
        else if (ack_clr) st_d.ack = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;
    assign flag_o   = st_q.flag;
    assign ack_o    = st_q.ack;
    assign irq_o    = st_q.irq;
    assign any_o    = hit;
    assign idx_o    = pick;

endmodule

// File: rtl/gie_vec_ram.sv
module gie_vec_ram #(
    parameter  int DEPTH = 256,
    parameter  int DW    = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    // contents carry no reset; software must fill slots before use
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/gie_regdec.sv
module gie_regdec import gie_pkg::*; #(
    parameter  int NUM_GROUPS = 12,
    parameter  int TBL_DEPTH  = 256,
    localparam int GW         = $clog2(NUM_GROUPS),
    localparam int TAW        = $clog2(TBL_DEPTH)
) (
    input  logic [15:0]    addr,
    output logic           hit_ctrl,
    output logic           hit_ack,
    output logic           hit_grp,
    output logic           is_flag,
    output logic [GW-1:0]  grp,
    output logic           hit_tbl,
    output logic [TAW-1:0] tbl_idx
);

    localparam logic [15:0] GRP_SPAN = 16'(2 * NUM_GROUPS);
    localparam logic [15:0] TBL_END  = TBL_BASE + 16'(TBL_DEPTH);

    logic [15:0] off;

    always_comb begin
        off      = addr - GRP_REG_BASE;
        hit_ctrl = (addr == CTRL_ADDR);
        hit_ack  = (addr == ACK_ADDR);
        hit_grp  = (addr >= GRP_REG_BASE) && (off < GRP_SPAN);
        // mask and pending words interleave: even offset = mask, odd = pending
        is_flag  = off[0];
        grp      = off[GW:1];
        hit_tbl  = (addr >= TBL_BASE) && (addr < TBL_END);
        // table base is aligned to its depth, so the low bits index it
        tbl_idx  = addr[TAW-1:0];
    end

endmodule

// File: rtl/gie_expander.sv
module gie_expander import gie_pkg::*; #(
    parameter  int NUM_GROUPS = 12,
    parameter  int GRP_SRCS   = 8,
    parameter  int DATA_W     = 16,
    parameter  int TBL_DEPTH  = 256,
    localparam int NUM_SRCS   = NUM_GROUPS * GRP_SRCS,
    localparam int GW         = $clog2(NUM_GROUPS),
    localparam int SW         = $clog2(GRP_SRCS),
    localparam int TAW        = $clog2(TBL_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRCS-1:0]   src_pulse,
    input  logic                  prot_ovr,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [15:0]           bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_GROUPS-1:0] cpu_irq,
    input  logic                  fetch_req,
    input  logic [GW-1:0]         fetch_line,
    input  logic                  fetch_trap,
    output logic                  fetch_valid,
    output logic [15:0]           fetch_addr
);

    localparam logic [15:0] GRP_STRIDE = 16'(GRP_SRCS * VEC_WORDS);

    typedef struct packed {
        logic              xen;
        logic              rd_ram;
        logic [DATA_W-1:0] rdata;
        logic              fv;
        logic [15:0]       faddr;
    } top_t;

    top_t st_d, st_q;

    logic           dec_hit_ctrl, dec_hit_ack, dec_hit_grp, dec_is_flag, dec_hit_tbl;
    logic [GW-1:0]  dec_grp;
    logic [TAW-1:0] dec_tbl_idx;

    logic [GRP_SRCS-1:0]   g_en   [NUM_GROUPS];
    logic [GRP_SRCS-1:0]   g_flag [NUM_GROUPS];
    logic [SW-1:0]         g_idx  [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] g_ack, g_irq, g_any;

    logic              wr_cyc, rd_cyc, xen_q, line_ok, ram_we;
    logic [GW-1:0]     line_s;
    logic [DATA_W-1:0] ram_rdata;
    logic [15:0]       vec_base;

    assign wr_cyc  = bus_en & bus_we;
    assign rd_cyc  = bus_en & ~bus_we;
    assign xen_q   = st_q.xen;
    assign line_ok = (16'(fetch_line) < 16'(NUM_GROUPS));
    assign line_s  = line_ok ? fetch_line : '0;
    assign ram_we  = wr_cyc & dec_hit_tbl & prot_ovr;

    gie_regdec #(
        .NUM_GROUPS (NUM_GROUPS),
        .TBL_DEPTH  (TBL_DEPTH)
    ) u_dec (
        .addr     (bus_addr),
        .hit_ctrl (dec_hit_ctrl),
        .hit_ack  (dec_hit_ack),
        .hit_grp  (dec_hit_grp),
        .is_flag  (dec_is_flag),
        .grp      (dec_grp),
        .hit_tbl  (dec_hit_tbl),
        .tbl_idx  (dec_tbl_idx)
    );

    gie_vec_ram #(
        .DEPTH (TBL_DEPTH),
        .DW    (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (dec_tbl_idx),
        .wdata (bus_wdata),
        .raddr (dec_tbl_idx),
        .rdata (ram_rdata)
    );

    for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
        logic sel_me;
        assign sel_me = (dec_grp == GW'(gi));

        gie_group #(
            .SRCS (GRP_SRCS)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_pulse (src_pulse[gi*GRP_SRCS +: GRP_SRCS]),
            .xen       (xen_q),
            .en_we     (wr_cyc & dec_hit_grp & ~dec_is_flag & sel_me),
            .flag_we   (wr_cyc & dec_hit_grp & dec_is_flag & sel_me),
            .wdata     (bus_wdata[GRP_SRCS-1:0]),
            .ack_clr   (wr_cyc & dec_hit_ack & bus_wdata[gi]),
            .take      (fetch_req & xen_q & ~fetch_trap & line_ok & (fetch_line == GW'(gi))),
            .enable_o  (g_en[gi]),
            .flag_o    (g_flag[gi]),
            .ack_o     (g_ack[gi]),
            .irq_o     (g_irq[gi]),
            .any_o     (g_any[gi]),
            .idx_o     (g_idx[gi])
        );
    end

    always_comb begin
        st_d     = st_q;
        vec_base = GRP_VEC_BASE + 16'(line_s) * GRP_STRIDE;

        if (wr_cyc && dec_hit_ctrl) st_d.xen = bus_wdata[0];

        if (rd_cyc) begin
            st_d.rd_ram = dec_hit_tbl;
            st_d.rdata  = '0;
            if (dec_hit_ctrl)     st_d.rdata[0] = st_q.xen;
            else if (dec_hit_ack) st_d.rdata[NUM_GROUPS-1:0] = g_ack;
            else if (dec_hit_grp) st_d.rdata[GRP_SRCS-1:0] =
                                      dec_is_flag ? g_flag[dec_grp] : g_en[dec_grp];
        end

        st_d.fv = fetch_req;
        if (fetch_req) begin
            if (!st_q.xen || !line_ok)
                st_d.faddr = CORE_SLOT_BASE + 16'(line_s) * 16'(VEC_WORDS);
            else if (fetch_trap || !g_any[line_s])
                st_d.faddr = vec_base;
            else
                st_d.faddr = vec_base + 16'(g_idx[line_s]) * 16'(VEC_WORDS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata   = st_q.rd_ram ? ram_rdata : st_q.rdata;
    assign cpu_irq     = g_irq;
    assign fetch_valid = st_q.fv;
    assign fetch_addr  = st_q.faddr;

endmodule

// File: rtl/gie_expander_chk.sv
module gie_expander_chk #(
    parameter int NUM_GROUPS = 12,
    parameter int DATA_W     = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  xen,
    input logic [NUM_GROUPS-1:0] cpu_irq,
    input logic                  fetch_req,
    input logic                  fetch_valid,
    input logic [15:0]           fetch_addr,
    input logic                  bus_en,
    input logic                  bus_we,
    input logic [15:0]           bus_addr,
    input logic [DATA_W-1:0]     bus_rdata
);

    // R3: a request pulse needs forwarding on in the previous cycle
    a_r3_irq_needs_xen: assert property (@(posedge clk) disable iff (!rst_n)
        (|cpu_irq) |-> $past(xen));

    // R4: the latch keeps every request to a single cycle
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_one
        a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[g] |=> !cpu_irq[g]);
    end

    // R5: fetch result follows the strobe by exactly one cycle
    a_r5_fetch_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_valid);
    a_r5_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !fetch_valid);

    // R5: every returned address is an even slot inside the table
    a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_addr >= 16'h0D02 && fetch_addr <= 16'h0DFE && !fetch_addr[0]));

    // R8: with forwarding off the fetch lands in the low core slots
    a_r8_core_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !$past(xen)) |-> (fetch_addr < 16'h0D40));

    // R11: reserved words read as zero
    a_r11_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr >= 16'h0CFA && bus_addr <= 16'h0CFF)
        |=> (bus_rdata == '0));

endmodule

bind gie_expander gie_expander_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .DATA_W     (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xen         (xen_q),
    .cpu_irq     (cpu_irq),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata)
);

// File: tb/gie_expander_tb.sv
module gie_expander_tb;

    localparam int NG   = 12;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_pulse = '0;
    logic            prot_ovr = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [NG-1:0]   cpu_irq;
    logic            fetch_req = 1'b0;
    logic [3:0]      fetch_line = '0;
    logic            fetch_trap = 1'b0;
    logic            fetch_valid;
    logic [15:0]     fetch_addr;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt [NG];

    always #4 clk = ~clk;

    gie_expander u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_pulse   (src_pulse),
        .prot_ovr    (prot_ovr),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cpu_irq     (cpu_irq),
        .fetch_req   (fetch_req),
        .fetch_line  (fetch_line),
        .fetch_trap  (fetch_trap),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr)
    );

    // count request pulses per line, sampled away from the active edge
    always @(negedge clk) begin
        for (int g = 0; g < NG; g++) begin
            if (!rst_n)          irq_cnt[g] = 0;
            else if (cpu_irq[g]) irq_cnt[g] = irq_cnt[g] + 1;
        end
    end

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%h expected 0x%h", what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic prot);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; prot_ovr = prot;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; prot_ovr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int i0, input int i1);
        @(negedge clk);
        src_pulse[i0] = 1'b1;
        if (i1 >= 0) src_pulse[i1] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic fetch(input int line, input logic trap, output logic [15:0] a);
        @(negedge clk);
        fetch_req = 1'b1; fetch_line = 4'(line); fetch_trap = trap;
        @(negedge clk);
        fetch_req = 1'b0; fetch_trap = 1'b0;
        check("R5 fetch_valid one cycle after strobe", {15'd0, fetch_valid}, 16'd1);
        a = fetch_addr;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        check("R1 request lines idle", 16'(cpu_irq), 16'h0000);
        check("R1 fetch_valid idle", {15'd0, fetch_valid}, 16'd0);
        rd(16'h0CE0, v); check("R1 control word", v, 16'h0000);
        rd(16'h0CE1, v); check("R1 latch word", v, 16'h0000);
        rd(16'h0CE2, v); check("R1 mask group 0", v, 16'h0000);
        rd(16'h0CF9, v); check("R1 pending group 11", v, 16'h0000);
    endtask

    task automatic t_flags();
        logic [15:0] v;
        do_reset();
        pulse(21, -1);
        rd(16'h0CE7, v); check("R2 pulse sets pending bit", v, 16'h0020);
        wr(16'h0CE7, 16'h0081, 1'b0);
        rd(16'h0CE7, v); check("R2 pending word written", v, 16'h0081);
        wr(16'h0CE6, 16'hFFF0, 1'b0);
        rd(16'h0CE6, v); check("R12 mask word zero-extended", v, 16'h00F0);
        wr(16'h0CE0, 16'hFFFF, 1'b0);
        rd(16'h0CE0, v); check("R12 control keeps bit 0 only", v, 16'h0001);
    endtask

    task automatic t_forward_ack();
        logic [15:0] v;
        do_reset();
        pulse(3, -1);
        wr(16'h0CE0, 16'h0001, 1'b0);
        idle(4);
        check("R3 masked source sends nothing", 16'(irq_cnt[0]), 16'd0);
        wr(16'h0CE2, 16'h0008, 1'b0);
        idle(4);
        check("R3 unmasked source sends one pulse", 16'(irq_cnt[0]), 16'd1);
        rd(16'h0CE1, v); check("R3 latch bit set", v, 16'h0001);
        pulse(3, -1);
        idle(5);
        check("R4 latched group stays quiet", 16'(irq_cnt[0]), 16'd1);
        wr(16'h0CE1, 16'h0000, 1'b0);
        idle(4);
        check("R4 writing zero keeps latch", 16'(irq_cnt[0]), 16'd1);
        wr(16'h0CE1, 16'h0001, 1'b0);
        idle(4);
        check("R4 release lets live group request again", 16'(irq_cnt[0]), 16'd2);
        rd(16'h0CE1, v); check("R4 latch set again", v, 16'h0001);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        do_reset();
        wr(16'h0CE0, 16'h0001, 1'b0);
        wr(16'h0CEA, 16'h00FF, 1'b0);
        pulse(38, 33);
        idle(2);
        fetch(4, 1'b0, v); check("R5 lowest index served first", v, 16'h0D82);
        rd(16'h0CEB, v);   check("R5 served bit cleared", v, 16'h0040);
        fetch(4, 1'b0, v); check("R5 next index served", v, 16'h0D8C);
        rd(16'h0CEB, v);   check("R5 pending empty", v, 16'h0000);
        wr(16'h0CEA, 16'h00FD, 1'b0);
        wr(16'h0CEB, 16'h0003, 1'b0);
        fetch(4, 1'b0, v); check("R5 masked bit skipped", v, 16'h0D80);
        rd(16'h0CEB, v);   check("R5 only served bit cleared", v, 16'h0002);
        fetch(4, 1'b0, v); check("R9 nothing live gives first slot", v, 16'h0D80);
        rd(16'h0CEB, v);   check("R9 masked pending untouched", v, 16'h0002);
    endtask

    task automatic t_late();
        logic [15:0] v;
        do_reset();
        wr(16'h0CE0, 16'h0001, 1'b0);
        wr(16'h0CF8, 16'h00FF, 1'b0);
        pulse(95, -1);
        idle(3);
        check("R6 request raised by late-index source", 16'(irq_cnt[11]), 16'd1);
        pulse(90, -1);
        fetch(11, 1'b0, v); check("R6 later higher-priority source wins", v, 16'h0DF4);
        fetch(11, 1'b0, v); check("R6 original source follows", v, 16'h0DFE);
    endtask

    task automatic t_trap_disabled();
        logic [15:0] v;
        do_reset();
        wr(16'h0CE0, 16'h0001, 1'b0);
        wr(16'h0CE4, 16'h00FF, 1'b0);
        wr(16'h0CE5, 16'h000C, 1'b0);
        fetch(1, 1'b1, v); check("R7 trap gives first slot", v, 16'h0D50);
        rd(16'h0CE5, v);   check("R7 trap clears nothing", v, 16'h000C);
        do_reset();
        wr(16'h0CEC, 16'h00FF, 1'b0);
        wr(16'h0CED, 16'h0001, 1'b0);
        idle(3);
        check("R8 no request with forwarding off", 16'(irq_cnt[5]), 16'd0);
        fetch(5, 1'b0, v); check("R8 core slot address", v, 16'h0D0C);
        rd(16'h0CED, v);   check("R8 pending untouched", v, 16'h0001);
    endtask

    task automatic t_table();
        logic [15:0] v;
        do_reset();
        wr(16'h0D40, 16'h1234, 1'b1);
        rd(16'h0D40, v); check("R10 write with override", v, 16'h1234);
        wr(16'h0D40, 16'hBEEF, 1'b0);
        rd(16'h0D40, v); check("R10 write without override blocked", v, 16'h1234);
        wr(16'h0DFF, 16'hA5A5, 1'b1);
        rd(16'h0DFF, v); check("R10 last table word", v, 16'hA5A5);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        do_reset();
        wr(16'h0CFA, 16'hFFFF, 1'b1);
        wr(16'h0CFF, 16'hFFFF, 1'b1);
        rd(16'h0CFA, v); check("R11 reserved low reads zero", v, 16'h0000);
        rd(16'h0CFF, v); check("R11 reserved high reads zero", v, 16'h0000);
        rd(16'h0CF8, v); check("R11 neighbour mask untouched", v, 16'h0000);
        rd(16'h0CF9, v); check("R11 neighbour pending untouched", v, 16'h0000);
        rd(16'h0CE0, v); check("R11 control untouched", v, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_flags();
        t_forward_ack();
        t_priority();
        t_late();
        t_trap_disabled();
        t_table();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule